// File: doc/BRIEF.md
# Write-First Register File

This block is a small synchronous register file with one write port and two independent read ports. Stored contents change only on a rising clock edge. A read is combinational. When the write port targets the same register that a read port is selecting in the same cycle, that read port returns the incoming write data and not the old stored value. A pipeline can therefore read a result in the cycle it is being written back, and no extra stall is needed.

Each read port has its own enable. A disabled port drives all zeros, which stands in for a released bus driver. A synchronous reset clears every register. The register count and data width are parameters, and the defaults are four registers of 32 bits with a 2-bit address. Internally, a control module decodes the write select and the per-port bypass and drive strobes. A datapath module holds the storage and the read multiplexers.

Top module: `regfile_wfirst`

## Requirements
- R1: With default parameters the address ports are 2 bits wide, addressing four registers, and all data ports are 32 bits wide.
- R2: On a rising clock edge with `wrEn` high, the register selected by `wrAddr` takes `wrData`, and later reads of that address return it.
- R3: A write changes only the addressed register. With `wrEn` low, no register changes.
- R4: When `rdEnA` is high, `wrEn` is high and `wrAddr` equals `rdAddrA`, `rdDataA` equals `wrData` in that same cycle.
- R5: Port B bypasses the same way as port A, and each port decides independently. A port whose address differs from `wrAddr` returns the stored value while the other port bypasses.
- R6: A read port whose enable is low outputs all zeros, even when its address matches an active write.
- R7: A synchronous active-high `rst` clears every register to zero on the clock edge, and it overrides a write in the same cycle.
- R8: Both read ports may select the same register at once, and both return its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write enable |
| wrAddr | input | ADDR_W (2) | Write register select |
| wrData | input | DATA_W (32) | Write data |
| rdEnA | input | 1 | Read port A enable |
| rdAddrA | input | ADDR_W (2) | Read port A register select |
| rdDataA | output | DATA_W (32) | Read port A data, zero when disabled |
| rdEnB | input | 1 | Read port B enable |
| rdAddrB | input | ADDR_W (2) | Read port B register select |
| rdDataB | output | DATA_W (32) | Read port B data, zero when disabled |

## Verification
Read results are due in the same cycle as the read inputs. The bench therefore drives each cycle's inputs on the falling edge and compares both read outputs one nanosecond later, before the next rising edge. Writes and resets take effect one rising edge later. The reference model applies them to its own array only after that cycle's comparison, so the next cycle's expected values include them. Directed steps cover the bypass, disable, reset-overrides-write and shared-address cases. A long pseudo-random run then compares the two ports against the model every cycle.

// File: rtl/regfile_wfirst_pkg.sv
`timescale 1ns/1ps
package regfile_wfirst_pkg;
  localparam int NUM_PORTS = 2;
  typedef struct packed {
    logic                 wrStrobe;
    logic [NUM_PORTS-1:0] portDrive;
    logic [NUM_PORTS-1:0] portBypass;
  } rfCtl_t;
endpackage

// File: rtl/rf_ctrl.sv
`timescale 1ns/1ps
module rf_ctrl
  import regfile_wfirst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [NUM_PORTS-1:0]              rdEn,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  rdAddr,
  output rfCtl_t                            ctl,
  output logic [NUM_REGS-1:0]               loadSel
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign loadSel[r] = wrEn && (wrAddr == ADDR_W'(r));
  end

  assign ctl.wrStrobe = wrEn;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign ctl.portDrive[p]  = rdEn[p];
    assign ctl.portBypass[p] = wrEn && (wrAddr == rdAddr[p]);
  end

  // R3: at most one register is loaded, and none without a write
  p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(loadSel));
  p_idle_no_load_r3: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> (loadSel == '0));
endmodule

// File: rtl/rf_dpath.sv
`timescale 1ns/1ps
module rf_dpath
  import regfile_wfirst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  rfCtl_t                            ctl,
  input  logic [NUM_REGS-1:0]               loadSel,
  input  logic [DATA_W-1:0]                 wrData,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  rdAddr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdData
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             regs[r] <= '0;
      else if (loadSel[r]) regs[r] <= wrData;
    end
    // R3: an unselected register keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!$past(loadSel[r]) && !$past(rst)) |-> $stable(regs[r]));
    // R7: reset leaves the register cleared
    p_reset_clear_r7: assert property (@(posedge clk)
      $past(rst) |-> (regs[r] == '0));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic [DATA_W-1:0] stored;
    always_comb begin
      stored = '0;
      for (int r = 0; r < NUM_REGS; r++)
        if (rdAddr[p] == ADDR_W'(r)) stored = regs[r];
    end
    always_comb begin
      if (!ctl.portDrive[p])       rdData[p] = '0;
      else if (ctl.portBypass[p])  rdData[p] = wrData;
      else                         rdData[p] = stored;
    end
    // R6: a released port shows zero
    p_release_zero_r6: assert property (@(posedge clk) disable iff (rst)
      !ctl.portDrive[p] |-> (rdData[p] == '0));
  end
endmodule

// File: rtl/regfile_wfirst.sv
`timescale 1ns/1ps
module regfile_wfirst
  import regfile_wfirst_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEnA,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic              rdEnB,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);
  rfCtl_t                           ctl;
  logic [NUM_REGS-1:0]              loadSel;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdData;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] rdAddr;

  assign rdAddr = {rdAddrB, rdAddrA};

  rf_ctrl #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .rdEn({rdEnB, rdEnA}), .rdAddr(rdAddr), .ctl(ctl), .loadSel(loadSel));

  rf_dpath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .loadSel(loadSel), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData));

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  // R4 / R5: same-cycle write is seen by a matching enabled port
  p_bypass_a_r4: assert property (@(posedge clk) disable iff (rst)
    (rdEnA && wrEn && wrAddr == rdAddrA) |-> (rdDataA == wrData));
  p_bypass_b_r5: assert property (@(posedge clk) disable iff (rst)
    (rdEnB && wrEn && wrAddr == rdAddrB) |-> (rdDataB == wrData));
  // R8: both ports on one address agree
  p_shared_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (rdEnA && rdEnB && rdAddrA == rdAddrB) |-> (rdDataA == rdDataB));
endmodule

// File: tb/regfile_wfirst_test.sv
`timescale 1ns/1ps
module regfile_wfirst_test;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst, wrEn, rdEnA, rdEnB;
  logic [AW-1:0] wrAddr, rdAddrA, rdAddrB;
  logic [DW-1:0] wrData, rdDataA, rdDataB;
  logic [DW-1:0] model [NR];
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regfile_wfirst uut (.clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdEnA(rdEnA), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdEnB(rdEnB), .rdAddrB(rdAddrB), .rdDataB(rdDataB));

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(logic en, logic [AW-1:0] ra);
    if (!en) return '0;
    if (wrEn && wrAddr == ra) return wrData;
    return model[ra];
  endfunction

  // one cycle: drive at falling edge, compare, then apply model update
  task automatic step(string tag, logic r, logic we, logic [AW-1:0] wa,
                      logic [DW-1:0] wd, logic ea, logic [AW-1:0] aa,
                      logic eb, logic [AW-1:0] ab);
    @(negedge clk);
    rst = r; wrEn = we; wrAddr = wa; wrData = wd;
    rdEnA = ea; rdAddrA = aa; rdEnB = eb; rdAddrB = ab;
    #1;
    check({tag, " portA"}, rdDataA, expect_rd(ea, aa));
    check({tag, " portB"}, rdDataB, expect_rd(eb, ab));
    if (r) foreach (model[i]) model[i] = '0;
    else if (we) model[wa] = wd;
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = '0;
    rst = 1; wrEn = 0; wrAddr = 0; wrData = 0;
    rdEnA = 0; rdAddrA = 0; rdEnB = 0; rdAddrB = 0;
    repeat (3) @(posedge clk);
    // R1: port widths
    nChecks++; if ($bits(wrAddr) != 2 || $bits(rdDataA) != 32) begin
      nFails++; $display("FAIL R1 widths actual=%0d/%0d expected=2/32",
                         $bits(wrAddr), $bits(rdDataA)); end
    // R7: reset state, all read zero
    for (int i = 0; i < NR; i++)
      step("R7 reset state", 0, 0, 0, 0, 1, AW'(i), 1, AW'(i));
    // R2: writes then reads
    for (int i = 0; i < NR; i++)
      step("R2 write", 0, 1, AW'(i), 32'hA000_0000 + i, 0, 0, 0, 0);
    for (int i = 0; i < NR; i++)
      step("R2 readback", 0, 0, 0, 0, 1, AW'(i), 1, AW'((i+1)%NR));
    // R3: idle write data ignored
    step("R3 idle", 0, 0, 2, 32'hDEAD_BEEF, 1, 2, 1, 1);
    step("R3 after idle", 0, 0, 0, 0, 1, 2, 1, 1);
    // R4: port A bypass
    step("R4 bypass A", 0, 1, 1, 32'h1111_2222, 1, 1, 1, 3);
    // R5: port B bypass while A reads other
    step("R5 bypass B", 0, 1, 3, 32'h3333_4444, 1, 0, 1, 3);
    step("R5 both bypass", 0, 1, 0, 32'h5555_6666, 1, 0, 1, 0);
    // R6: disabled ports zero even on match
    step("R6 disabled", 0, 1, 2, 32'h7777_8888, 0, 2, 0, 2);
    step("R6 check stored", 0, 0, 0, 0, 1, 2, 0, 1);
    // R8: same address both ports
    step("R8 shared", 0, 0, 0, 0, 1, 3, 1, 3);
    // R7: reset overrides write
    step("R7 reset+write", 1, 1, 1, 32'hFFFF_0000, 0, 0, 0, 0);
    for (int i = 0; i < NR; i++)
      step("R7 cleared", 0, 0, 0, 0, 1, AW'(i), 1, AW'(i));
    // random run against the model (R2 R3 R4 R5 R6 R8)
    for (int n = 0; n < 2000; n++)
      step("R2-mix random", ($urandom % 97) == 0, $urandom % 2,
           AW'($urandom), $urandom, ($urandom % 4) != 0, AW'($urandom),
           ($urandom % 4) != 0, AW'($urandom));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule